// File: doc/BRIEF.md
# Signed Redundant-Binary Multiplier

This block multiplies two signed operands held in redundant-binary form. Every digit takes a value of -1, 0 or +1 and travels as two bits: a plus bit and a minus bit. The digit value is plus minus minus. The operand value is the sum of the digit values, each weighted by 2^i.

Each operand is cut into a low half and a high half. Four small generators run side by side and form the low-by-low, low-by-high, high-by-low and high-by-high partial products in redundant-binary form. Each generator first turns its two halves into small two's-complement values. It does this on its own, with no carry from any neighbouring half. The aligned partial products are then summed by carry-free redundant-binary adders, so the adder delay does not grow with the operand width.

The product comes out as redundant-binary digits. An optional output register holds it for one cycle.

Top module: `rb_sgn_mul`

## Requirements
- R1: Each digit i of an operand is the pair (plus[i], minus[i]) with value plus[i] - minus[i]. The pairs (0,0) and (1,1) both mean zero.
- R2: The product value, the sum over all digits of (p_plus[i] - p_minus[i]) * 2^i, equals the integer product of the two operand values for every pair of legal operand encodings.
- R3: Partial products are weighted by position: low-by-low at digit 0, both cross products at digit DIGITS/2, and high-by-high at digit DIGITS. A product formed only by the high half of one operand and the low half of the other therefore equals that cross product times 2^(DIGITS/2).
- R4: No product digit is ever driven as the pair (1,1). Every product digit is (1,0), (0,1) or (0,0).
- R5: Operand value 5 times operand value -10 gives a product value of -50.
- R6: With REG_OUT=1, the product of the inputs present at a rising clock edge appears after that edge and is stable until the next one. While rst_n is low, every product bit is 0.
- R7: The extreme operands, +15 and -15 for four digits in any sign combination, give +225 or -225. The final adder never loses a carry out of its top digit.
- R8: Two different encodings of the same operand value give the same product value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the output register |
| a_plus | input | DIGITS | Plus bits of operand A |
| a_minus | input | DIGITS | Minus bits of operand A |
| b_plus | input | DIGITS | Plus bits of operand B |
| b_minus | input | DIGITS | Minus bits of operand B |
| p_plus | output | 2*DIGITS+1 | Plus bits of the product |
| p_minus | output | 2*DIGITS+1 | Minus bits of the product |

## Verification
All of the arithmetic is combinational. With the default output register, a product is due one rising edge after its operands are applied. The bench changes operands on a falling edge and reads the product on the next falling edge, which is the first moment after that register has loaded. One nanosecond after each change of operands, the bench also confirms that the output still shows the previous product, so that a path that skips the register is caught. The run sweeps every encoding pair of two four-digit operands, then adds seeded random pairs and directed cases for alignment, mixed encodings and the extreme values.

// File: rtl/rb_mul_pkg.sv
package rb_mul_pkg;

    // Weighted value of a redundant-binary word held in two bit vectors.
    function automatic int rb_value(input logic [31:0] pos, input logic [31:0] neg);
        int acc;
        acc = 0;
        for (int i = 0; i < 31; i++) begin
            acc += (int'(pos[i]) - int'(neg[i])) * (1 << i);
        end
        return acc;
    endfunction

    function automatic int abs_int(input int v);
        return (v < 0) ? -v : v;
    endfunction

endpackage

// File: rtl/rb_half_to_tc.sv
module rb_half_to_tc #(
    parameter int HALF = 2
) (
    input  logic [HALF-1:0]        pos,
    input  logic [HALF-1:0]        neg,
    output logic signed [HALF:0]   tc
);
    localparam int LIMIT = (1 << HALF) - 1;

    // Each half is converted on its own: no carry enters or leaves (R3).
    always_comb begin
        tc = $signed({1'b0, pos}) - $signed({1'b0, neg});
        a_r3_half_range: assert (int'(tc) <= LIMIT && int'(tc) >= -LIMIT)
            else $error("half value out of range");
    end
endmodule

// File: rtl/rb_pp_gen.sv
module rb_pp_gen #(
    parameter int HALF = 2
) (
    input  logic [HALF-1:0]   a_pos,
    input  logic [HALF-1:0]   a_neg,
    input  logic [HALF-1:0]   b_pos,
    input  logic [HALF-1:0]   b_neg,
    output logic [2*HALF-1:0] pp_pos,
    output logic [2*HALF-1:0] pp_neg
);
    import rb_mul_pkg::*;

    localparam int PPW    = 2 * HALF;
    localparam int PP_MAX = ((1 << HALF) - 1) * ((1 << HALF) - 1);

    logic signed [HALF:0]  ta;
    logic signed [HALF:0]  tb;
    logic signed [PPW+1:0] prod;
    logic        [PPW+1:0] mag;

    rb_half_to_tc #(.HALF(HALF)) u_cvt_a (.pos(a_pos), .neg(a_neg), .tc(ta));
    rb_half_to_tc #(.HALF(HALF)) u_cvt_b (.pos(b_pos), .neg(b_neg), .tc(tb));

    // Signed product of the two small halves, re-encoded as sign and magnitude.
    always_comb begin
        prod = ta * tb;
        mag  = prod[PPW+1] ? unsigned'(-prod) : unsigned'(prod);
        pp_pos = prod[PPW+1] ? '0 : mag[PPW-1:0];
        pp_neg = prod[PPW+1] ? mag[PPW-1:0] : '0;
    end

    always_comb begin
        a_r3_pp_bound: assert (mag[PPW+1:PPW] == 2'b00 &&
                               abs_int(rb_value(32'(pp_pos), 32'(pp_neg))) <= PP_MAX)
            else $error("partial product magnitude too large");
    end
endmodule

// File: rtl/rb_cf_add.sv
module rb_cf_add #(
    parameter int W = 9
) (
    input  logic [W-1:0] x_pos,
    input  logic [W-1:0] x_neg,
    input  logic [W-1:0] y_pos,
    input  logic [W-1:0] y_neg,
    output logic [W-1:0] z_pos,
    output logic [W-1:0] z_neg
);
    logic signed [1:0] dx [W];
    logic signed [1:0] dy [W];
    logic signed [2:0] sm [W];
    logic              nn [W];
    logic signed [1:0] s  [W];
    logic signed [1:0] c  [W+1];
    logic signed [2:0] z  [W];

    // Step 1: digit sums and lower-neighbour sign flags.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            dx[i] = $signed({1'b0, x_pos[i]}) - $signed({1'b0, x_neg[i]});
            dy[i] = $signed({1'b0, y_pos[i]}) - $signed({1'b0, y_neg[i]});
            sm[i] = {dx[i][1], dx[i]} + {dy[i][1], dy[i]};
        end
        nn[0] = 1'b1;
        for (int i = 1; i < W; i++) begin
            nn[i] = !dx[i-1][1] && !dy[i-1][1];
        end
    end

    // Step 2: intermediate sum and carry. The carry choice looks only at
    // the digit pair one position below.
    always_comb begin
        c[0] = 2'sd0;
        for (int i = 0; i < W; i++) begin
            case (sm[i])
                3'sd2:  begin c[i+1] = 2'sd1;  s[i] = 2'sd0; end
                -3'sd2: begin c[i+1] = -2'sd1; s[i] = 2'sd0; end
                3'sd1:  begin
                    c[i+1] = nn[i] ? 2'sd1 : 2'sd0;
                    s[i]   = nn[i] ? -2'sd1 : 2'sd1;
                end
                -3'sd1: begin
                    c[i+1] = nn[i] ? 2'sd0 : -2'sd1;
                    s[i]   = nn[i] ? -2'sd1 : 2'sd1;
                end
                default: begin c[i+1] = 2'sd0; s[i] = 2'sd0; end
            endcase
        end
    end

    // Step 3: final digit is sum plus incoming carry, with no further carry.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            z[i]     = {s[i][1], s[i]} + {c[i][1], c[i]};
            z_pos[i] = (z[i] == 3'sd1);
            z_neg[i] = (z[i] == -3'sd1);
            a_r4_digit_range: assert (z[i] != 3'sd2 && z[i] != -3'sd2)
                else $error("adder digit %0d out of range", i);
        end
        a_r7_no_overflow: assert (!((dx[W-1] == 2'sd0) && (dy[W-1] == 2'sd0)) || (c[W] == 2'sd0))
            else $error("carry lost from top digit");
    end
endmodule

// File: rtl/rb_sgn_mul.sv
module rb_sgn_mul #(
    parameter int DIGITS  = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIGITS-1:0]     a_plus,
    input  logic [DIGITS-1:0]     a_minus,
    input  logic [DIGITS-1:0]     b_plus,
    input  logic [DIGITS-1:0]     b_minus,
    output logic [2*DIGITS:0]     p_plus,
    output logic [2*DIGITS:0]     p_minus
);
    import rb_mul_pkg::*;

    localparam int HALF    = DIGITS / 2;
    localparam int PPW     = 2 * HALF;
    localparam int CW      = PPW + 1;
    localparam int PW      = 2 * DIGITS + 1;
    localparam int PAD_TOP = PW - CW - HALF;
    localparam int MAXMAG  = ((1 << DIGITS) - 1) * ((1 << DIGITS) - 1);

    // Quadrant q: bit 1 selects the half of A, bit 0 selects the half of B.
    logic [PPW-1:0] pp_pos [4];
    logic [PPW-1:0] pp_neg [4];

    for (genvar q = 0; q < 4; q++) begin : g_quad
        localparam int AOFF = ((q >> 1) & 1) * HALF;
        localparam int BOFF = (q & 1) * HALF;
        rb_pp_gen #(.HALF(HALF)) u_pp (
            .a_pos  (a_plus [AOFF +: HALF]),
            .a_neg  (a_minus[AOFF +: HALF]),
            .b_pos  (b_plus [BOFF +: HALF]),
            .b_neg  (b_minus[BOFF +: HALF]),
            .pp_pos (pp_pos[q]),
            .pp_neg (pp_neg[q])
        );
    end

    // Cross products share weight 2^HALF: add them first.
    logic [CW-1:0] cross_pos, cross_neg;
    rb_cf_add #(.W(CW)) u_add_cross (
        .x_pos ({1'b0, pp_pos[1]}),
        .x_neg ({1'b0, pp_neg[1]}),
        .y_pos ({1'b0, pp_pos[2]}),
        .y_neg ({1'b0, pp_neg[2]}),
        .z_pos (cross_pos),
        .z_neg (cross_neg)
    );

    // Low-by-low at offset 0 and high-by-high at offset DIGITS do not overlap.
    logic [PW-1:0] outer_pos, outer_neg, mid_pos, mid_neg;
    always_comb begin
        outer_pos = {1'b0, pp_pos[3], pp_pos[0]};
        outer_neg = {1'b0, pp_neg[3], pp_neg[0]};
        mid_pos   = {{PAD_TOP{1'b0}}, cross_pos, {HALF{1'b0}}};
        mid_neg   = {{PAD_TOP{1'b0}}, cross_neg, {HALF{1'b0}}};
    end

    logic [PW-1:0] sum_pos, sum_neg;
    rb_cf_add #(.W(PW)) u_add_final (
        .x_pos (outer_pos),
        .x_neg (outer_neg),
        .y_pos (mid_pos),
        .y_neg (mid_neg),
        .z_pos (sum_pos),
        .z_neg (sum_neg)
    );

    always_comb begin
        a_r2_value: assert (rb_value(32'(sum_pos), 32'(sum_neg)) ==
                            rb_value(32'(a_plus), 32'(a_minus)) * rb_value(32'(b_plus), 32'(b_minus)))
            else $error("product value mismatch");
        a_r7_range: assert (abs_int(rb_value(32'(sum_pos), 32'(sum_neg))) <= MAXMAG)
            else $error("product out of range");
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_plus  <= '0;
                p_minus <= '0;
            end else begin
                p_plus  <= sum_pos;
                p_minus <= sum_neg;
            end
        end

        a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (rb_value(32'(p_plus), 32'(p_minus)) ==
                      $past(rb_value(32'(a_plus), 32'(a_minus)) * rb_value(32'(b_plus), 32'(b_minus)))))
            else $error("registered product wrong");

        a_r4_no_both: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((p_plus & p_minus) == '0))
            else $error("product digit encoded as both bits");
    end else begin : g_comb
        always_comb begin
            p_plus  = sum_pos;
            p_minus = sum_neg;
        end
    end
endmodule

// File: tb/rb_sgn_mul_tb_top.sv
`timescale 1ns/1ps
module rb_sgn_mul_tb_top;
    localparam int D  = 4;
    localparam int PW = 2 * D + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [D-1:0]  a_p, a_m, b_p, b_m;
    logic [PW-1:0] q_p, q_m;

    rb_sgn_mul #(.DIGITS(D), .REG_OUT(1'b1)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_plus  (a_p),
        .a_minus (a_m),
        .b_plus  (b_p),
        .b_minus (b_m),
        .p_plus  (q_p),
        .p_minus (q_m)
    );

    int total = 0;
    int bad = 0;
    int prev_exp = 0;
    int last_got = 0;
    bit finished = 1'b0;

    function automatic int dec(input logic [PW-1:0] p, input logic [PW-1:0] m);
        int acc = 0;
        for (int i = 0; i < PW; i++) acc += (int'(p[i]) - int'(m[i])) * (1 << i);
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the next falling edge.
    task automatic run(input logic [D-1:0] ap, input logic [D-1:0] am,
                       input logic [D-1:0] bp, input logic [D-1:0] bm, input string req);
        int exp;
        int got;
        a_p = ap; a_m = am; b_p = bp; b_m = bm;
        #1;
        got = dec(q_p, q_m);
        check(got == prev_exp, "R6 output held before edge", got, prev_exp);
        @(posedge clk);
        @(negedge clk);
        exp = dec(PW'(ap), PW'(am)) * dec(PW'(bp), PW'(bm));
        got = dec(q_p, q_m);
        check(got == exp, req, got, exp);
        check((q_p & q_m) == '0, "R4 digit encoding", int'(q_p & q_m), 0);
        prev_exp = exp;
        last_got = got;
    endtask

    initial begin
        int ref_val;
        a_p = '0; a_m = '0; b_p = 4'b0011; b_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(q_p == '0 && q_m == '0, "R6 reset clears", int'(q_p | q_m), 0);
        rst_n = 1'b1;
        prev_exp = 0;
        run(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R2 zero");

        // R5: 5 = 8-4+1, -10 = -8-2
        run(4'b1001, 4'b0100, 4'b0000, 4'b1010, "R5 five times minus ten");
        check(last_got == -50, "R5 value", last_got, -50);

        // R1: all digits (1,1) mean zero
        run(4'b1111, 4'b1111, 4'b0111, 4'b0000, "R1 both-bit digits are zero");
        check(last_got == 0, "R1 value", last_got, 0);
        run(4'b0011, 4'b0010, 4'b0001, 4'b0000, "R1 mixed pair");

        // R3: placement of each quadrant
        run(4'b0001, 4'b0000, 4'b0001, 4'b0000, "R3 low by low");
        check(last_got == 1, "R3 low-low offset", last_got, 1);
        run(4'b0100, 4'b0000, 4'b0001, 4'b0000, "R3 high by low");
        check(last_got == 4, "R3 cross offset", last_got, 4);
        run(4'b0001, 4'b0000, 4'b1000, 4'b0000, "R3 low by high");
        check(last_got == 8, "R3 cross offset upper", last_got, 8);
        run(4'b0100, 4'b0000, 4'b0100, 4'b0000, "R3 high by high");
        check(last_got == 16, "R3 high-high offset", last_got, 16);

        // R7: extremes
        run(4'b1111, 4'b0000, 4'b1111, 4'b0000, "R7 max times max");
        check(last_got == 225, "R7 plus", last_got, 225);
        run(4'b1111, 4'b0000, 4'b0000, 4'b1111, "R7 max times min");
        check(last_got == -225, "R7 minus", last_got, -225);
        run(4'b0000, 4'b1111, 4'b0000, 4'b1111, "R7 min times min");
        check(last_got == 225, "R7 both negative", last_got, 225);

        // R8: value 3 as 0011 and as 0100-0001
        run(4'b0011, 4'b0000, 4'b0101, 4'b0010, "R8 first encoding");
        ref_val = last_got;
        run(4'b0100, 4'b0001, 4'b0101, 4'b0010, "R8 second encoding");
        check(last_got == ref_val, "R8 same value", last_got, ref_val);
        run(4'b1111, 4'b1100, 4'b0101, 4'b0010, "R8 third encoding");
        check(last_got == ref_val, "R8 same value again", last_got, ref_val);

        // R2: every encoding pair
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [7:0] xv;
                logic [7:0] yv;
                xv = 8'(x);
                yv = 8'(y);
                run(xv[7:4], xv[3:0], yv[7:4], yv[3:0], "R2 sweep");
            end
        end

        // R2: seeded random pairs
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2000; k++) begin
            logic [15:0] rv;
            rv = 16'($urandom);
            run(rv[15:12], rv[11:8], rv[7:4], rv[3:0], "R2 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule